// File: doc/BRIEF.md
# Accumulator Readout Rounding and Flag Unit

This block turns a 48-bit multiply-accumulate accumulator into a 32-bit register value and derives the accumulator status flags from it. The readout format follows two mode bits. In fractional mode the value is taken either as a 16-bit fraction, always rounded at bit 24, or as a 32-bit fraction, rounded or truncated at bit 8. With both mode bits clear the readout is an unsigned integer, and with only the signed bit set it is a signed integer. A saturation-control bit decides whether an out-of-range fractional result is clamped or wraps. Integer readouts are always clamped.

The flag path works on the same accumulator input. It reports zero, negative, overflow (copied from that accumulator's stored overflow bit) and extension-significance, where the last test depends on the data mode. The readout and the flag evaluation each have their own strobe. Each registers its result one cycle after its strobe, which matches a single-cycle register-move. The registered values hold until the next strobe.

Top module: `mac_readout_unit`

## Requirements
- R1: With ctl_frac=1 and ctl_su=1, the result is accumulator bits 39..24 rounded to nearest-even using bits 23..0 as remainder: above 0x800000 adds one, exactly 0x800000 adds the value's bit 0. It appears in rd_data[15:0] with rd_data[31:16]=0.
- R2: In the 16-bit mode, a rounding carry beyond 16 bits with ctl_omc=1 gives 0x7FFF when accumulator bit 47 is 0 and 0x8000 when it is 1. With ctl_omc=0 it gives the low 16 bits.
- R3: With ctl_frac=1 and ctl_su=0, the value is the accumulator shifted arithmetically right by 8. When ctl_rnd=1 it is rounded to nearest-even against bits 7..0, with 0x80 as the half point. When ctl_rnd=0 it is truncated.
- R4: In the 32-bit fractional mode with ctl_omc=1, a rounded value outside 0..0xFFFFFFFF gives 0x7FFFFFFF if it is non-negative and 0 if it is negative. With ctl_omc=0 the low 32 bits are returned.
- R5: With ctl_frac=0 and ctl_su=1, an accumulator within the signed 32-bit range is returned as its low 32 bits. Otherwise the result is 0x7FFFFFFF when bit 47 is 0 and 0x80000000 when it is 1. ctl_rnd and ctl_omc have no effect.
- R6: With ctl_frac=0 and ctl_su=0, the low 32 bits are returned when bits 47..32 are zero, and 0xFFFFFFFF otherwise. ctl_rnd and ctl_omc have no effect.
- R7: flg_z is 1 exactly when the accumulator is zero. flg_n is 1 exactly when the accumulator is non-zero and bit 47 is set.
- R8: flg_v equals acc_pav.
- R9: flg_ev is set when bits 47..40 are neither all zeros nor all ones in fractional mode, and when bits 47..32 are neither all zeros nor all ones in signed mode. In unsigned mode it is set when any of bits 47..32 is set.
- R10: rd_data and rd_vld update in the cycle after rd_stb. flg_* and flg_vld update in the cycle after flg_stb. rd_vld and flg_vld are single-cycle pulses, data outputs hold without a strobe, and both strobes may fall in the same cycle.
- R11: A synchronous active-high rst clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_val | input | 48 | Accumulator value, two's complement |
| ctl_frac | input | 1 | Fractional data mode |
| ctl_su | input | 1 | Signed (integer) or 16-bit (fractional) select |
| ctl_rnd | input | 1 | Round the 32-bit fractional readout |
| ctl_omc | input | 1 | Saturate fractional readouts on overflow |
| acc_pav | input | 1 | Stored overflow bit of this accumulator |
| rd_stb | input | 1 | Capture a readout |
| flg_stb | input | 1 | Capture a flag evaluation |
| rd_data | output | 32 | Registered readout |
| rd_vld | output | 1 | Pulse: rd_data was updated |
| flg_n | output | 1 | Negative flag |
| flg_z | output | 1 | Zero flag |
| flg_ev | output | 1 | Extension-significance flag |
| flg_v | output | 1 | Overflow flag |
| flg_vld | output | 1 | Pulse: flags were updated |

## Verification
The readout and the flag evaluation can both be captured in one cycle from the same accumulator and mode bits. Directed cycles assert rd_stb and flg_stb together on boundary values such as half-way remainders, rounding carries into saturation and sign-edge integers. The random phase sets each strobe independently, so joint, single and idle cycles all occur. Every cycle the bench compares both registered outputs with a behavioural model, and that also shows a strobe on one path leaves the other path's held value unchanged.

// File: rtl/mac_ro_pkg.sv
package mac_ro_pkg;

    typedef enum logic [1:0] {
        RO_UINT = 2'd0,
        RO_SINT = 2'd1,
        RO_FRAC = 2'd2
    } ro_mode_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ext;
        logic ovf;
    } ro_flags_t;

    function automatic ro_mode_e ro_decode(input logic frac, input logic su);
        if (frac)
            return RO_FRAC;
        else if (su)
            return RO_SINT;
        else
            return RO_UINT;
    endfunction

    function automatic logic uniform_bits16(input logic [15:0] v);
        return (v == 16'h0000) || (v == 16'hFFFF);
    endfunction

    function automatic logic uniform_bits8(input logic [7:0] v);
        return (v == 8'h00) || (v == 8'hFF);
    endfunction

endpackage

// File: rtl/mac_ro_rne.sv
// Shift right by SH with round-half-even on the dropped bits.
module mac_ro_rne #(
    parameter int IN_W = 48,
    parameter int SH   = 8
) (
    input  logic [IN_W-1:0]  din,
    input  logic             rnd_en,
    output logic [IN_W-SH:0] q
);
    localparam int Q_W = IN_W - SH + 1;
    localparam logic [SH-1:0] HALF = {1'b1, {(SH-1){1'b0}}};

    logic [Q_W-1:0] base;
    logic [SH-1:0]  rem;
    logic           inc;

    always_comb begin
        base = {din[IN_W-1], din[IN_W-1:SH]};
        rem  = din[SH-1:0];
        inc  = rnd_en && ((rem > HALF) || ((rem == HALF) && base[0]));
        q    = base + {{(Q_W-1){1'b0}}, inc};
    end
endmodule

// File: rtl/mac_ro_frac.sv
// Fractional readout: 16-bit rounded or 32-bit rounded/truncated, optional clamp.
module mac_ro_frac #(
    parameter int ACC_W     = 48,
    parameter int RES_W     = 32,
    parameter int SHORT_W   = 16,
    parameter int FINE_SH   = 8,
    parameter int COARSE_SH = 24
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             su,
    input  logic             rnd,
    input  logic             omc,
    output logic [RES_W-1:0] res
);
    localparam int SIN_W = COARSE_SH + SHORT_W + 1;
    localparam int SQ_W  = SIN_W - COARSE_SH + 1;
    localparam int LQ_W  = ACC_W - FINE_SH + 1;
    localparam logic [SHORT_W-1:0] SAT_POS = {1'b0, {(SHORT_W-1){1'b1}}};
    localparam logic [SHORT_W-1:0] SAT_NEG = {1'b1, {(SHORT_W-1){1'b0}}};
    localparam logic [RES_W-1:0]   LSAT_POS = {1'b0, {(RES_W-1){1'b1}}};

    logic [SIN_W-1:0] short_in;
    logic [SQ_W-1:0]  short_q;
    logic [LQ_W-1:0]  long_q;
    logic             short_ovf;
    logic             long_fit;
    logic [SHORT_W-1:0] short_res;
    logic [RES_W-1:0]   long_res;

    assign short_in = {1'b0, acc[COARSE_SH+SHORT_W-1:0]};

    mac_ro_rne #(.IN_W(SIN_W), .SH(COARSE_SH)) u_rne_short (
        .din    (short_in),
        .rnd_en (1'b1),
        .q      (short_q)
    );

    mac_ro_rne #(.IN_W(ACC_W), .SH(FINE_SH)) u_rne_long (
        .din    (acc),
        .rnd_en (rnd),
        .q      (long_q)
    );

    always_comb begin
        short_ovf = |short_q[SQ_W-1:SHORT_W];
        long_fit  = ~|long_q[LQ_W-1:RES_W];

        if (omc && short_ovf)
            short_res = acc[ACC_W-1] ? SAT_NEG : SAT_POS;
        else
            short_res = short_q[SHORT_W-1:0];

        if (omc && !long_fit)
            long_res = long_q[LQ_W-1] ? '0 : LSAT_POS;
        else
            long_res = long_q[RES_W-1:0];

        res = su ? {{(RES_W-SHORT_W){1'b0}}, short_res} : long_res;
    end
endmodule

// File: rtl/mac_ro_int.sv
// Integer readout with unconditional clamping.
module mac_ro_int #(
    parameter int ACC_W = 48,
    parameter int RES_W = 32
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             signed_mode,
    output logic [RES_W-1:0] res
);
    localparam logic [RES_W-1:0] S_MAX = {1'b0, {(RES_W-1){1'b1}}};
    localparam logic [RES_W-1:0] S_MIN = {1'b1, {(RES_W-1){1'b0}}};

    logic s_fit;
    logic u_fit;

    always_comb begin
        s_fit = (&acc[ACC_W-1:RES_W-1]) || (~|acc[ACC_W-1:RES_W-1]);
        u_fit = ~|acc[ACC_W-1:RES_W];
        if (signed_mode)
            res = s_fit ? acc[RES_W-1:0] : (acc[ACC_W-1] ? S_MIN : S_MAX);
        else
            res = u_fit ? acc[RES_W-1:0] : '1;
    end
endmodule

// File: rtl/mac_ro_flags.sv
// Status flag evaluation for one accumulator.
module mac_ro_flags #(
    parameter int ACC_W   = 48,
    parameter int RES_W   = 32,
    parameter int FINE_SH = 8
) (
    input  logic [ACC_W-1:0]        acc,
    input  mac_ro_pkg::ro_mode_e    mode,
    input  logic                    pav,
    output mac_ro_pkg::ro_flags_t   flags
);
    import mac_ro_pkg::*;

    localparam int FH_W = FINE_SH;
    localparam int IH_W = ACC_W - RES_W;

    logic [FH_W-1:0] frac_hi;
    logic [IH_W-1:0] int_hi;
    logic            is_zero;

    always_comb begin
        frac_hi = acc[ACC_W-1:ACC_W-FH_W];
        int_hi  = acc[ACC_W-1:RES_W];
        is_zero = (acc == '0);

        flags.zero = is_zero;
        flags.neg  = !is_zero && acc[ACC_W-1];
        flags.ovf  = pav;
        unique case (mode)
            RO_FRAC: flags.ext = !((frac_hi == '0) || (frac_hi == '1));
            RO_SINT: flags.ext = !((int_hi == '0) || (int_hi == '1));
            default: flags.ext = |int_hi;
        endcase
    end
endmodule

// File: rtl/mac_readout_unit.sv
module mac_readout_unit #(
    parameter int ACC_W     = 48,
    parameter int RES_W     = 32,
    parameter int SHORT_W   = 16,
    parameter int FINE_SH   = 8,
    parameter int COARSE_SH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] acc_val,
    input  logic             ctl_frac,
    input  logic             ctl_su,
    input  logic             ctl_rnd,
    input  logic             ctl_omc,
    input  logic             acc_pav,
    input  logic             rd_stb,
    input  logic             flg_stb,
    output logic [RES_W-1:0] rd_data,
    output logic             rd_vld,
    output logic             flg_n,
    output logic             flg_z,
    output logic             flg_ev,
    output logic             flg_v,
    output logic             flg_vld
);
    import mac_ro_pkg::*;

    ro_mode_e           mode;
    logic [RES_W-1:0]   frac_res;
    logic [RES_W-1:0]   int_res;
    logic [RES_W-1:0]   rd_next;
    ro_flags_t          flg_next;
    ro_flags_t          flg_q;

    assign mode = ro_decode(ctl_frac, ctl_su);

    mac_ro_frac #(
        .ACC_W(ACC_W), .RES_W(RES_W), .SHORT_W(SHORT_W),
        .FINE_SH(FINE_SH), .COARSE_SH(COARSE_SH)
    ) u_frac (
        .acc (acc_val),
        .su  (ctl_su),
        .rnd (ctl_rnd),
        .omc (ctl_omc),
        .res (frac_res)
    );

    mac_ro_int #(.ACC_W(ACC_W), .RES_W(RES_W)) u_int (
        .acc         (acc_val),
        .signed_mode (ctl_su),
        .res         (int_res)
    );

    mac_ro_flags #(.ACC_W(ACC_W), .RES_W(RES_W), .FINE_SH(FINE_SH)) u_flags (
        .acc   (acc_val),
        .mode  (mode),
        .pav   (acc_pav),
        .flags (flg_next)
    );

    assign rd_next = (mode == RO_FRAC) ? frac_res : int_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
            flg_q   <= '0;
            flg_vld <= 1'b0;
        end else begin
            rd_vld  <= rd_stb;
            flg_vld <= flg_stb;
            if (rd_stb)
                rd_data <= rd_next;
            if (flg_stb)
                flg_q <= flg_next;
        end
    end

    assign flg_n  = flg_q.neg;
    assign flg_z  = flg_q.zero;
    assign flg_ev = flg_q.ext;
    assign flg_v  = flg_q.ovf;
endmodule

// File: rtl/mac_ro_checker.sv
module mac_ro_checker #(
    parameter int ACC_W = 48,
    parameter int RES_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic [ACC_W-1:0] acc_val,
    input logic             ctl_frac,
    input logic             ctl_su,
    input logic             acc_pav,
    input logic             rd_stb,
    input logic             flg_stb,
    input logic [RES_W-1:0] rd_data,
    input logic             rd_vld,
    input logic             flg_n,
    input logic             flg_z,
    input logic             flg_v,
    input logic             flg_vld
);
    // R1: 16-bit fractional readout leaves the upper half clear
    assert_short_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && ctl_frac && ctl_su) |=> (rd_data[RES_W-1:16] == '0));

    // R6: unsigned readout with high bits set clamps to all ones
    assert_uint_clamp_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !ctl_frac && !ctl_su && (acc_val[ACC_W-1:RES_W] != '0))
        |=> (rd_data == '1));

    // R7: zero and negative never together
    assert_z_n_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        flg_vld |-> !(flg_z && flg_n));

    assert_zero_acc_sets_z_R7: assert property (@(posedge clk) disable iff (rst)
        (flg_stb && (acc_val == '0)) |=> flg_z);

    // R8: overflow flag copies the accumulator's stored bit
    assert_v_copies_pav_R8: assert property (@(posedge clk) disable iff (rst)
        flg_stb |=> (flg_v == $past(acc_pav)));

    // R10: strobe-to-valid latency and holding
    assert_rd_vld_follows_R10: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_vld);

    assert_rd_vld_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> !rd_vld);

    assert_flg_vld_follows_R10: assert property (@(posedge clk) disable iff (rst)
        flg_stb |=> flg_vld);

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_data));

    // R11: reset clears outputs
    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> ((rd_data == '0) && !rd_vld && !flg_vld && !flg_z && !flg_n && !flg_v));
endmodule

bind mac_readout_unit mac_ro_checker #(.ACC_W(ACC_W), .RES_W(RES_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .acc_val  (acc_val),
    .ctl_frac (ctl_frac),
    .ctl_su   (ctl_su),
    .acc_pav  (acc_pav),
    .rd_stb   (rd_stb),
    .flg_stb  (flg_stb),
    .rd_data  (rd_data),
    .rd_vld   (rd_vld),
    .flg_n    (flg_n),
    .flg_z    (flg_z),
    .flg_v    (flg_v),
    .flg_vld  (flg_vld)
);

// File: tb/mac_readout_unit_bench.sv
module mac_readout_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [47:0] acc_val;
    logic        ctl_frac, ctl_su, ctl_rnd, ctl_omc, acc_pav;
    logic        rd_stb, flg_stb;
    logic [31:0] rd_data;
    logic        rd_vld, flg_n, flg_z, flg_ev, flg_v, flg_vld;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [31:0] e_data;
    logic        e_rvld, e_fvld;
    logic [3:0]  e_flg;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_readout_unit u_mac_readout_unit (
        .clk(clk), .rst(rst), .acc_val(acc_val),
        .ctl_frac(ctl_frac), .ctl_su(ctl_su), .ctl_rnd(ctl_rnd), .ctl_omc(ctl_omc),
        .acc_pav(acc_pav), .rd_stb(rd_stb), .flg_stb(flg_stb),
        .rd_data(rd_data), .rd_vld(rd_vld),
        .flg_n(flg_n), .flg_z(flg_z), .flg_ev(flg_ev), .flg_v(flg_v), .flg_vld(flg_vld)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic longint sx(logic [47:0] a);
        return longint'({{16{a[47]}}, a});
    endfunction

    function automatic logic [31:0] ref_read(longint a, bit fr, bit su, bit rn, bit om);
        longint v, rem;
        longint smax, smin;
        smax = (longint'(1) <<< 31) - 1;
        smin = -(longint'(1) <<< 31);
        if (fr && su) begin
            rem = a & 64'hFFFFFF;
            v   = (a >>> 24) & 64'hFFFF;
            if (rem > 64'h800000) v = v + 1;
            else if (rem == 64'h800000) v = v + (v & 1);
            if (v > 64'hFFFF)
                return om ? ((a < 0) ? 32'h8000 : 32'h7FFF) : 32'(v & 64'hFFFF);
            return 32'(v);
        end else if (fr) begin
            rem = a & 64'hFF;
            v   = a >>> 8;
            if (rn) begin
                if (rem > 64'h80) v = v + 1;
                else if (rem == 64'h80) v = v + (v & 1);
            end
            if (om && (v < 0)) return 32'h0;
            if (om && (v > 64'hFFFFFFFF)) return 32'h7FFFFFFF;
            return 32'(v);
        end else if (su) begin
            if (a >= smin && a <= smax) return 32'(a);
            return (a < 0) ? 32'h80000000 : 32'h7FFFFFFF;
        end else begin
            if ((a >>> 32) == 0) return 32'(a);
            return 32'hFFFFFFFF;
        end
    endfunction

    // returns {n, z, ev, v}
    function automatic logic [3:0] ref_flags(longint a, bit fr, bit su, bit pav);
        bit n, z, ev;
        longint h;
        z = (a == 0);
        n = !z && (a < 0);
        if (fr) begin
            h  = a >>> 40;
            ev = (h != 0) && (h != -1);
        end else if (su) begin
            h  = a >>> 32;
            ev = (h != 0) && (h != -1);
        end else begin
            ev = ((a >>> 32) != 0);
        end
        return {n, z, ev, pav};
    endfunction

    function automatic string mode_tag(bit fr, bit su);
        if (fr && su) return "R1";
        if (fr) return "R3";
        if (su) return "R5";
        return "R6";
    endfunction

    // One clock: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(logic [47:0] a, bit fr, bit su, bit rn, bit om, bit pav,
                       bit rs, bit fs, string tag);
        longint av;
        acc_val = a; ctl_frac = fr; ctl_su = su; ctl_rnd = rn; ctl_omc = om;
        acc_pav = pav; rd_stb = rs; flg_stb = fs;
        @(posedge clk);
        av = sx(a);
        if (rs) e_data = ref_read(av, fr, su, rn, om);
        if (fs) e_flg  = ref_flags(av, fr, su, pav);
        e_rvld = rs;
        e_fvld = fs;
        @(negedge clk);
        check(rs ? tag : "R10", "rd_data", rd_data, e_data);
        check("R10", "rd_vld", {31'b0, rd_vld}, {31'b0, e_rvld});
        check(fs ? "R7 R8 R9" : "R10", "flags{n,z,ev,v}",
              {28'b0, flg_n, flg_z, flg_ev, flg_v}, {28'b0, e_flg});
        check("R10", "flg_vld", {31'b0, flg_vld}, {31'b0, e_fvld});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; acc_val = '0; ctl_frac = 0; ctl_su = 0; ctl_rnd = 0; ctl_omc = 0;
        acc_pav = 0; rd_stb = 0; flg_stb = 0;
        e_data = '0; e_rvld = 0; e_fvld = 0; e_flg = '0;
        repeat (3) @(negedge clk);
        // R11: outputs cleared while in reset
        check("R11", "rd_data", rd_data, 32'h0);
        check("R11", "valids", {30'b0, rd_vld, flg_vld}, 32'h0);
        check("R11", "flags", {28'b0, flg_n, flg_z, flg_ev, flg_v}, 32'h0);
        rst = 1'b0;

        // R1: half-way remainder, even value stays; odd value rounds up
        cyc(48'h00_1234_800000, 1, 1, 0, 0, 0, 1, 1, "R1");
        cyc(48'h00_1235_800000, 1, 1, 0, 0, 0, 1, 1, "R1");
        cyc(48'h00_1234_800001, 1, 1, 0, 0, 0, 1, 0, "R1");
        cyc(48'h00_1234_7FFFFF, 1, 1, 0, 0, 0, 1, 0, "R1");
        // R2: carry out of 16 bits, positive and negative, with and without clamp
        cyc(48'h00_FFFF_FFFFFF, 1, 1, 0, 1, 0, 1, 1, "R2");
        cyc(48'h00_FFFF_FFFFFF, 1, 1, 0, 0, 0, 1, 1, "R2");
        cyc(48'hFF_FFFF_FFFFFF, 1, 1, 0, 1, 1, 1, 1, "R2");
        // R3: round vs truncate at bit 8
        cyc(48'h0000_0001_0080, 1, 0, 1, 0, 0, 1, 1, "R3");
        cyc(48'h0000_0001_8180, 1, 0, 1, 0, 0, 1, 0, "R3");
        cyc(48'h0000_0001_8180, 1, 0, 0, 0, 0, 1, 0, "R3");
        cyc(48'hFFFF_FFFF_FF81, 1, 0, 1, 0, 0, 1, 1, "R3");
        // R4: 32-bit clamp, including a rounding carry into overflow
        cyc(48'h0100_0000_0000, 1, 0, 0, 1, 0, 1, 1, "R4");
        cyc(48'h00FF_FFFF_FFFF, 1, 0, 1, 1, 0, 1, 1, "R4");
        cyc(48'h00FF_FFFF_FFFF, 1, 0, 0, 1, 0, 1, 1, "R4");
        cyc(48'hFFFF_FFFF_FF00, 1, 0, 0, 1, 0, 1, 1, "R4");
        cyc(48'hFFFF_FFFF_FF00, 1, 0, 0, 0, 0, 1, 1, "R4");
        // R5: signed integer edges; rnd/omc set to show they have no effect
        cyc(48'h0000_7FFF_FFFF, 0, 1, 1, 1, 0, 1, 1, "R5");
        cyc(48'h0000_8000_0000, 0, 1, 1, 1, 0, 1, 1, "R5");
        cyc(48'hFFFF_8000_0000, 0, 1, 0, 0, 0, 1, 1, "R5");
        cyc(48'hFFFF_7FFF_FFFF, 0, 1, 1, 0, 1, 1, 1, "R5");
        // R6: unsigned integer edges
        cyc(48'h0000_FFFF_FFFF, 0, 0, 1, 1, 0, 1, 1, "R6");
        cyc(48'h0001_0000_0000, 0, 0, 0, 0, 0, 1, 1, "R6");
        cyc(48'h8000_0000_0000, 0, 0, 0, 1, 0, 1, 1, "R6");
        // R7: zero and negative flags; R9: mode-dependent extension test
        cyc(48'h0, 1, 0, 0, 0, 1, 0, 1, "R7");
        cyc(48'h00FF_0000_0000, 1, 0, 0, 0, 0, 0, 1, "R9");
        cyc(48'h0100_0000_0000, 1, 0, 0, 0, 0, 0, 1, "R9");
        cyc(48'hFF00_0000_0000, 1, 0, 0, 0, 0, 0, 1, "R9");
        cyc(48'hFFFF_8000_0000, 0, 1, 0, 0, 0, 0, 1, "R9");
        cyc(48'hFFFF_8000_0000, 0, 0, 0, 0, 0, 0, 1, "R9");
        // R10: idle cycles hold both paths; one path alone leaves the other
        cyc(48'h1234_5678_9ABC, 1, 0, 1, 1, 1, 0, 0, "R10");
        cyc(48'h1234_5678_9ABC, 0, 0, 0, 0, 1, 1, 0, "R10");
        cyc(48'h0, 0, 0, 0, 0, 0, 0, 1, "R10");

        // Random phase: modes, strobes and accumulator shapes mixed
        for (int i = 0; i < 600; i++) begin
            logic [47:0] a;
            logic [31:0] r1, r2;
            int shape;
            r1 = $urandom; r2 = $urandom;
            shape = $urandom % 5;
            case (shape)
                0: a = {r2[15:0], r1};
                1: a = {{16{r1[31]}}, r1};
                2: a = {r2[0] ? 16'hFFFF : 16'h0000, r1} ^ {15'b0, r2[1], 32'b0};
                3: a = {r2[15:0], r1[31:24], 24'h800000};
                default: a = {r2[15:0], r1[31:8], 8'h80};
            endcase
            cyc(a, r2[16], r2[17], r2[18], r2[19], r2[20], r2[21], r2[22],
                mode_tag(r2[16], r2[17]));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule